// File: doc/BRIEF.md
# Serial Receiver with Error Capture

This block turns an asynchronous serial input line into received characters. A tick input runs at a fixed multiple of the bit rate. The block uses that tick to find a start bit, confirm it at the centre of the bit, and take 5 to 8 data bits, least significant first. When parity is on, it also takes a parity bit, and it always samples one stop bit. Each character is stored as a 12-bit entry in a one-deep holding register. The entry holds the data and four error flags: framing, parity, break and overrun. The host side sees the entry on a read port, takes it with a read strobe, and sees empty/full flags for the register.

A separate 4-bit status register shows the framing, parity and break flags of the character read most recently. It copies those flags only when an entry is taken through the read strobe. The overrun flag in this register is different: it is set in the same cycle that a character arrives while the holding register is still occupied. A write strobe clears all four status flags.

The receive sequencer is a state machine with six states:
- `RX_IDLE` waits for a low line on a tick while reception is enabled, then moves to `RX_START`.
- `RX_START` checks the line at mid-bit. A high line rejects the start and returns to `RX_IDLE`; a low line moves to `RX_DATA`.
- `RX_DATA` samples one bit per bit period. After the last data bit it moves to `RX_PARITY` when parity is on, and to `RX_STOP` when it is off.
- `RX_PARITY` samples the parity bit and moves to `RX_STOP`.
- `RX_STOP` samples the stop bit and stores the entry. It returns to `RX_IDLE`, or goes to `RX_BRK_WAIT` after a break.
- `RX_BRK_WAIT` waits for the line to go high again before returning to `RX_IDLE`.

Top module: `serial_rx_capture`

## Requirements
- R1: After reset, `rx_empty` is 1, `rx_full` is 0, `stat_flags` is 0 and `rd_word` is 0.
- R2: Each bit is sampled at the middle of its bit period. A low pulse on the line that has ended by the mid-point of the start bit is rejected, and nothing is stored.
- R3: `word_len` sets the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. The data bits arrive least significant first and appear in `rd_word[7:0]`; bits above the word length read as 0.
- R4: When `par_en` is 1, a parity bit follows the data. The expected parity bit depends on `par_stick` and `par_even`:
  - with `par_stick` = 1, it is 1 when `par_even` = 0 and 0 when `par_even` = 1;
  - with `par_stick` = 0 and `par_even` = 1, it is the XOR of the data bits;
  - with `par_stick` = 0 and `par_even` = 0, it is the inverse of that XOR.

  A mismatch sets entry bit 9. When `par_en` is 0, no parity bit is taken.
- R5: A stop bit sampled low sets entry bit 8. Only one stop bit is checked, so a new start bit may follow the first stop bit directly.
- R6: A frame whose data, parity and stop positions are all low is a break. It stores one entry of value 0x400 (only bit 10 set). No new start is accepted until the line has gone high.
- R7: A stored entry sets `rx_full` and clears `rx_empty`. A read strobe while full empties the register. `rd_word` reads 0 whenever the register is empty.
- R8: A character that completes while the register is full and no read occurs in that cycle is discarded. In the next cycle, entry bit 11 is set in the held entry and `stat_flags[3]` is 1.
- R9: A read strobe while full loads `stat_flags[2:0]` (framing, parity, break) from entry bits 10:8. Without such a read those bits do not change, except through a clear. A read strobe while empty has no effect.
- R10: A `stat_wr` strobe clears all four status flags. A load or overrun set in the same cycle takes precedence over the clear.
- R11: While `rx_enable` is 0, no new start bit is accepted. A frame already in progress still completes and is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at OVERSAMPLE times the bit rate |
| rx_in | input | 1 | Serial input line, idle high |
| rx_enable | input | 1 | Allows new start bits to be accepted |
| word_len | input | 2 | Data bit count code (00 = 5 bits through 11 = 8 bits) |
| par_en | input | 1 | Expect and check a parity bit |
| par_even | input | 1 | Even parity select (selects the fixed level in stick mode) |
| par_stick | input | 1 | Stick parity select |
| rd_data | input | 1 | Read strobe: takes the held entry |
| rd_word | output | 12 | Held entry: {overrun, break, parity, framing, data[7:0]} |
| rx_empty | output | 1 | Holding register is empty |
| rx_full | output | 1 | Holding register holds an entry |
| stat_wr | input | 1 | Write strobe that clears the status flags |
| stat_flags | output | 4 | Status flags {overrun, break, parity, framing} |

## Verification
The bench builds the block with OVERSAMPLE = 8 and a tick every second clock, so one bit lasts 16 clocks. That keeps each frame short enough to run every word length, each parity rule, a break and back-to-back frames well inside the run. A mid-bit sample falls 8 clocks into each bit, so a 4-clock glitch reliably tests start rejection. Driving two frames with no gap between them reaches the overrun path and the single-stop-bit rule in one stimulus. Changing `rx_enable` inside a `fork` reaches the rule that a frame in progress completes.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_BRK_WAIT
    } rx_state_e;

    localparam int DATA_MAX = 8;
    localparam int ENTRY_W  = DATA_MAX + 4;

    // Packed order puts overrun at bit 11, data at bits 7:0.
    typedef struct packed {
        logic                ovr;
        logic                brk;
        logic                par;
        logic                frm;
        logic [DATA_MAX-1:0] data;
    } rx_entry_t;

    function automatic logic expected_parity(
        input logic [DATA_MAX-1:0] d,
        input logic                even_sel,
        input logic                stick
    );
        if (stick) begin
            return ~even_sel;
        end
        return even_sel ? (^d) : ~(^d);
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '1;
        end else begin
            sh <= {sh[STAGES-2:0], d};
        end
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/rx_deframer.sv
module rx_deframer
    import serial_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rx,
    input  logic      enable,
    input  logic [1:0] word_len,
    input  logic      par_en,
    input  logic      par_even,
    input  logic      par_stick,
    output logic      push,
    output rx_entry_t push_entry
);
    localparam int CW = $clog2(OVERSAMPLE);
    localparam logic [CW-1:0] MID_CNT  = CW'(OVERSAMPLE / 2 - 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(OVERSAMPLE - 1);

    rx_state_e state, state_nxt;

    logic [CW-1:0]       cnt;
    logic [2:0]          bit_idx;
    logic [DATA_MAX-1:0] shreg;
    logic                par_rx;
    logic                mid_pt;
    logic                bit_pt;
    logic [2:0]          last_idx;
    logic                is_break;

    assign mid_pt   = tick && (cnt == MID_CNT);
    assign bit_pt   = tick && (cnt == LAST_CNT);
    assign last_idx = 3'd4 + {1'b0, word_len};
    assign is_break = !rx && (shreg == '0) && (!par_en || !par_rx);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            RX_IDLE: begin
                if (tick && enable && !rx) state_nxt = RX_START;
            end
            RX_START: begin
                if (mid_pt) state_nxt = rx ? RX_IDLE : RX_DATA;
            end
            RX_DATA: begin
                if (bit_pt && (bit_idx == last_idx)) begin
                    state_nxt = par_en ? RX_PARITY : RX_STOP;
                end
            end
            RX_PARITY: begin
                if (bit_pt) state_nxt = RX_STOP;
            end
            RX_STOP: begin
                if (bit_pt) state_nxt = is_break ? RX_BRK_WAIT : RX_IDLE;
            end
            RX_BRK_WAIT: begin
                if (rx) state_nxt = RX_IDLE;
            end
            default: state_nxt = RX_IDLE;
        endcase
    end

    // sampling datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_rx  <= 1'b0;
        end else begin
            unique case (state)
                RX_IDLE, RX_BRK_WAIT: begin
                    cnt     <= '0;
                    bit_idx <= '0;
                    shreg   <= '0;
                    par_rx  <= 1'b0;
                end
                RX_START: begin
                    if (mid_pt) begin
                        cnt <= '0;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA, RX_PARITY, RX_STOP: begin
                    if (tick) begin
                        cnt <= (cnt == LAST_CNT) ? '0 : cnt + 1'b1;
                    end
                    if (bit_pt && state == RX_DATA) begin
                        shreg[bit_idx] <= rx;
                        bit_idx        <= bit_idx + 1'b1;
                    end
                    if (bit_pt && state == RX_PARITY) begin
                        par_rx <= rx;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        push            = (state == RX_STOP) && bit_pt;
        push_entry.data = shreg;
        push_entry.ovr  = 1'b0;
        push_entry.brk  = is_break;
        push_entry.frm  = !rx && !is_break;
        push_entry.par  = par_en && !is_break &&
                          (par_rx != expected_parity(shreg, par_even, par_stick));
    end
endmodule

// File: rtl/rx_hold_reg.sv
module rx_hold_reg
    import serial_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  rx_entry_t push_entry,
    input  logic      rd,
    output rx_entry_t entry,
    output logic      empty,
    output logic      full,
    output logic      ovr_evt,
    output logic      rd_ok
);
    rx_entry_t held;
    logic      valid;

    assign rd_ok   = rd && valid;
    assign ovr_evt = push && valid && !rd_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held  <= '0;
            valid <= 1'b0;
        end else if (push && (!valid || rd_ok)) begin
            held  <= push_entry;
            valid <= 1'b1;
        end else if (ovr_evt) begin
            held.ovr <= 1'b1;
        end else if (rd_ok) begin
            held  <= '0;
            valid <= 1'b0;
        end
    end

    assign entry = held;
    assign empty = !valid;
    assign full  = valid;
endmodule

// File: rtl/rx_status_reg.sv
module rx_status_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       load,
    input  logic [2:0] load_flags,
    input  logic       ovr_set,
    output logic [3:0] flags
);
    logic [3:0] flags_nxt;

    always_comb begin
        flags_nxt = clr ? 4'b0 : flags;
        if (load)    flags_nxt[2:0] = load_flags;
        if (ovr_set) flags_nxt[3]   = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= 4'b0;
        end else begin
            flags <= flags_nxt;
        end
    end
endmodule

// File: rtl/serial_rx_capture.sv
module serial_rx_capture
    import serial_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         baud_tick,
    input  logic         rx_in,
    input  logic         rx_enable,
    input  logic [1:0]   word_len,
    input  logic         par_en,
    input  logic         par_even,
    input  logic         par_stick,
    input  logic         rd_data,
    output logic [11:0]  rd_word,
    output logic         rx_empty,
    output logic         rx_full,
    input  logic         stat_wr,
    output logic [3:0]   stat_flags
);
    logic      rx_s;
    logic      push;
    rx_entry_t push_entry;
    rx_entry_t held;
    logic      ovr_evt;
    logic      rd_ok;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_in),
        .q     (rx_s)
    );

    rx_deframer #(.OVERSAMPLE(OVERSAMPLE)) u_deframer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (baud_tick),
        .rx         (rx_s),
        .enable     (rx_enable),
        .word_len   (word_len),
        .par_en     (par_en),
        .par_even   (par_even),
        .par_stick  (par_stick),
        .push       (push),
        .push_entry (push_entry)
    );

    rx_hold_reg u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_entry (push_entry),
        .rd         (rd_data),
        .entry      (held),
        .empty      (rx_empty),
        .full       (rx_full),
        .ovr_evt    (ovr_evt),
        .rd_ok      (rd_ok)
    );

    rx_status_reg u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (stat_wr),
        .load       (rd_ok),
        .load_flags ({held.brk, held.par, held.frm}),
        .ovr_set    (ovr_evt),
        .flags      (stat_flags)
    );

    assign rd_word = held;
endmodule

// File: rtl/serial_rx_capture_chk.sv
module serial_rx_capture_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_data,
    input logic        stat_wr,
    input logic        push,
    input logic        rx_empty,
    input logic        rx_full,
    input logic [11:0] rd_word,
    input logic [3:0]  stat_flags
);
    // R7
    empty_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty |-> (rd_word == 12'h000));

    // R7
    read_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && rx_full && !push) |=> rx_empty);

    // R8
    overrun_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && push && !rd_data) |=> (stat_flags[3] && rd_word[11]));

    // R9
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_wr && !(rd_data && !rx_empty)) |=> $stable(stat_flags[2:0]));

    // R10
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !(rd_data && !rx_empty)) |=> (stat_flags[2:0] == 3'b000));

    // R6
    break_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_word[10] |-> (rd_word[9:0] == 10'h000));
endmodule

bind serial_rx_capture serial_rx_capture_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_data    (rd_data),
    .stat_wr    (stat_wr),
    .push       (push),
    .rx_empty   (rx_empty),
    .rx_full    (rx_full),
    .rd_word    (rd_word),
    .stat_flags (stat_flags)
);

// File: tb/serial_rx_capture_bench.sv
module serial_rx_capture_bench;
    localparam int OVS      = 8;
    localparam int TICK_DIV = 2;
    localparam int BIT_CLK  = OVS * TICK_DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        baud_tick = 1'b0;
    logic        rx_in = 1'b1;
    logic        rx_enable = 1'b1;
    logic [1:0]  word_len = 2'b11;
    logic        par_en = 1'b0;
    logic        par_even = 1'b0;
    logic        par_stick = 1'b0;
    logic        rd_data = 1'b0;
    logic [11:0] rd_word;
    logic        rx_empty;
    logic        rx_full;
    logic        stat_wr = 1'b0;
    logic [3:0]  stat_flags;

    int n_checks = 0;
    int n_fail   = 0;
    logic [11:0] exp_q[$];

    always #2 clk = ~clk;

    int tdiv = 0;
    always @(negedge clk) begin
        tdiv      <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        baud_tick <= (tdiv == TICK_DIV - 1);
    end

    serial_rx_capture #(.OVERSAMPLE(OVS), .SYNC_STAGES(2)) u_serial_rx_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .rx_in      (rx_in),
        .rx_enable  (rx_enable),
        .word_len   (word_len),
        .par_en     (par_en),
        .par_even   (par_even),
        .par_stick  (par_stick),
        .rd_data    (rd_data),
        .rd_word    (rd_word),
        .rx_empty   (rx_empty),
        .rx_full    (rx_full),
        .stat_wr    (stat_wr),
        .stat_flags (stat_flags)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic send_bit(input logic b);
        rx_in = b;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    function automatic logic [7:0] data_mask(input logic [1:0] wl);
        return 8'hFF >> (3 - wl);
    endfunction

    function automatic logic model_parity(input logic [7:0] d);
        if (par_stick) return ~par_even;
        return par_even ? (^d) : ~(^d);
    endfunction

    // driver: sends one frame; returns the entry the requirements predict
    task automatic send_frame(input logic [7:0] d, input logic bad_par,
                              input logic bad_stop, output logic [11:0] exp);
        logic [7:0] dm;
        int nb;
        dm = d & data_mask(word_len);
        nb = 5 + int'(word_len);
        exp = {2'b00, bad_par & par_en, bad_stop, dm};
        send_bit(1'b0);
        for (int i = 0; i < nb; i++) send_bit(dm[i]);
        if (par_en) send_bit(model_parity(dm) ^ bad_par);
        send_bit(~bad_stop);
        rx_in = 1'b1;
    endtask

    task automatic frame_and_queue(input logic [7:0] d, input logic bad_par, input logic bad_stop);
        logic [11:0] e;
        send_frame(d, bad_par, bad_stop, e);
        exp_q.push_back(e);
        send_bit(1'b1);
    endtask

    task automatic strobe_read();
        rd_data = 1'b1;
        @(negedge clk);
        rd_data = 1'b0;
    endtask

    task automatic strobe_clear();
        stat_wr = 1'b1;
        @(negedge clk);
        stat_wr = 1'b0;
    endtask

    // monitor: pops the expected entry and compares what the design holds
    task automatic pop_and_check(input string req);
        logic [11:0] e;
        e = exp_q.pop_front();
        check({req, " full before read R7"}, rx_full, 1'b1);
        check({req, " entry"}, rd_word, e);
        strobe_read();
        check({req, " empty after read R7"}, rx_empty, 1'b1);
        check({req, " status load R9"}, stat_flags[2:0], e[10:8]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [11:0] dummy;
        repeat (4) @(negedge clk);
        // R1 reset values
        check("R1 rx_empty", rx_empty, 1'b1);
        check("R1 rx_full", rx_full, 1'b0);
        check("R1 stat_flags", stat_flags, 4'h0);
        check("R1 rd_word", rd_word, 12'h000);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R3 eight bits, no parity
        frame_and_queue(8'hA5, 1'b0, 1'b0);
        pop_and_check("R3 8-bit A5");
        // R3 five bits: upper bits zero
        word_len = 2'b00;
        frame_and_queue(8'hF5, 1'b0, 1'b0);
        pop_and_check("R3 5-bit");
        word_len = 2'b01;
        frame_and_queue(8'h2A, 1'b0, 1'b0);
        pop_and_check("R3 6-bit");

        // R4 parity rules, 7-bit words
        word_len = 2'b10; par_en = 1'b1;
        par_even = 1'b1; par_stick = 1'b0;
        frame_and_queue(8'h53, 1'b0, 1'b0);
        pop_and_check("R4 even good");
        par_even = 1'b0;
        frame_and_queue(8'h53, 1'b0, 1'b0);
        pop_and_check("R4 odd good");
        frame_and_queue(8'h14, 1'b1, 1'b0);
        pop_and_check("R4 odd bad");
        check("R4 parity flag in status", stat_flags[1], 1'b1);
        par_stick = 1'b1;
        frame_and_queue(8'h33, 1'b0, 1'b0);
        pop_and_check("R4 stick one good");
        par_even = 1'b1;
        frame_and_queue(8'h33, 1'b1, 1'b0);
        pop_and_check("R4 stick zero bad");
        par_en = 1'b0; par_stick = 1'b0; word_len = 2'b11;

        // R5 framing error
        frame_and_queue(8'h3C, 1'b0, 1'b1);
        pop_and_check("R5 framing");
        check("R5 framing flag in status", stat_flags[0], 1'b1);

        // R9 read while empty leaves status and word alone
        strobe_read();
        check("R9 empty read keeps status", stat_flags, 4'b0001);
        check("R7 empty word zero", rd_word, 12'h000);

        // R10 clear
        strobe_clear();
        check("R10 status cleared", stat_flags, 4'h0);

        // R8 and R5: back-to-back frames with a single stop bit
        send_frame(8'h11, 1'b0, 1'b0, dummy);
        send_frame(8'h22, 1'b0, 1'b0, dummy);
        send_bit(1'b1);
        check("R8 overrun status immediate", stat_flags[3], 1'b1);
        exp_q.push_back(12'h811);
        pop_and_check("R8 held entry keeps first char R5");
        check("R8 second char discarded", rx_empty, 1'b1);
        strobe_clear();
        check("R10 overrun cleared", stat_flags, 4'h0);

        // R6 break with parity enabled
        par_en = 1'b1; par_even = 1'b1;
        rx_in = 1'b0;
        repeat (14 * BIT_CLK) @(negedge clk);
        rx_in = 1'b1;
        repeat (2 * BIT_CLK) @(negedge clk);
        exp_q.push_back(12'h400);
        pop_and_check("R6 break entry");
        check("R6 single break entry", rx_empty, 1'b1);
        check("R6 break in status", stat_flags[2], 1'b1);
        par_en = 1'b0;
        strobe_clear();

        // R2 short glitch is rejected
        rx_in = 1'b0;
        repeat (4) @(negedge clk);
        rx_in = 1'b1;
        repeat (12 * BIT_CLK) @(negedge clk);
        check("R2 glitch rejected", rx_empty, 1'b1);

        // R11 disabled receiver ignores a frame
        rx_enable = 1'b0;
        send_frame(8'h5A, 1'b0, 1'b0, dummy);
        send_bit(1'b1);
        check("R11 disabled no entry", rx_empty, 1'b1);
        rx_enable = 1'b1;

        // R11 disable during a frame: frame still completes
        fork
            frame_and_queue(8'hC3, 1'b0, 1'b0);
            begin
                repeat (3 * BIT_CLK) @(negedge clk);
                rx_enable = 1'b0;
            end
        join
        pop_and_check("R11 frame in progress completes");
        rx_enable = 1'b1;

        finish_up();
    end
endmodule